// File: doc/BRIEF.md
# Status Register Write Controller

This block holds a coprocessor Status register and applies privileged software writes to it. A write changes only the bits that the configurable writable-bit mask allows. When the release-6 rules are on, some written values are filtered out: a request for the reserved privilege level 3 is dropped when the privilege field is fully writable, and the soft-reset and NMI flags can be cleared but cannot be set.

When the multithreading feature is on, every accepted write also copies the coprocessor-usable bits, the MX bit and the privilege field, together with the current address-space ID, into a per-thread-context TCStatus word. If the addressed context is the one running now, the copy goes to the active-context register. Otherwise it goes to the backing entry for that index. A user-mode qualifier blocks every write.

Top module: `status_wr_unit`

## Requirements
- R1: An accepted write sets Status to (old & ~mask) | (wrData & mask), where mask is the effective mask. Outside release-6 mode the effective mask equals rwMask, so bits outside rwMask never change.
- R2: A synchronous reset loads Status with the parameter RESET_STATUS and clears the active TCStatus register and every backing TCStatus entry.
- R3: In release-6 mode, when rwMask[4:3] is 2'b11 and wrData[4:3] is 2'b11, bits 4:3 (the privilege field) of Status keep their old value. When rwMask[4:3] is not 2'b11, those bits follow R1.
- R4: In release-6 mode, a 1 written to bit 20 (SR) or bit 19 (NMI) is dropped, and a 0 written to either bit clears it if the bit is writable.
- R5: Outside release-6 mode, privilege value 3 and 1s on bits 20 and 19 are written like any other masked bits.
- R6: With mtEnable high, an accepted write places the new Status bits 31:28 in TCStatus 31:28, Status bit 24 in TCStatus bit 27, and Status bits 4:3 in TCStatus 12:11.
- R7: The same write places asidIn in TCStatus 7:0 and keeps every other TCStatus bit at its previous value.
- R8: When targetTc equals currentTc, only the active TCStatus register is updated. Otherwise only backing entry targetTc is updated. No other TCStatus word changes.
- R9: With mtEnable low, no TCStatus word changes.
- R10: While userMode is high, wrEn has no effect on Status or on any TCStatus word.
- R11: Status and TCStatus show the written values from the clock edge that samples wrEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Value to write |
| rwMask | input | 32 | Writable-bit mask |
| r6Mode | input | 1 | Enables the release-6 write filtering |
| mtEnable | input | 1 | Enables the TCStatus mirroring |
| userMode | input | 1 | Blocks all writes |
| asidIn | input | 8 | Current address-space ID |
| targetTc | input | TC_IDX_W | Addressed thread context |
| currentTc | input | TC_IDX_W | Running thread context |
| statusOut | output | 32 | Status register |
| activeTcStatus | output | 32 | TCStatus of the running context |
| tcStatusFlat | output | NUM_TC*32 | Backing TCStatus entries, entry i at bits 32*i+31:32*i |

## Verification
The assertions assume that every input is at a known level on each sampled edge, and that rst is held high for at least one edge before any write. The mask-stability check compares against the rwMask seen on the write edge, so it places no limit on how often rwMask changes. The bench drives inputs only on falling edges, holds reset for several cycles first, and then draws random data, masks, mode flags and context indices. These draws always stay inside the index range and never leave a signal unknown.

// File: rtl/stat_wr_pkg.sv
package stat_wr_pkg;
  localparam int WORD_W = 32;
  // Status field positions
  localparam int ST_CU_HI = 31;
  localparam int ST_CU_LO = 28;
  localparam int ST_MX = 24;
  localparam int ST_SR = 20;
  localparam int ST_NMI = 19;
  localparam int ST_KSU_HI = 4;
  localparam int ST_KSU_LO = 3;
  // TCStatus field positions
  localparam int TC_TCU_HI = 31;
  localparam int TC_TCU_LO = 28;
  localparam int TC_TMX = 27;
  localparam int TC_TKSU_HI = 12;
  localparam int TC_TKSU_LO = 11;
  localparam int TC_ASID_HI = 7;
  localparam int ASID_W = TC_ASID_HI + 1;
  localparam logic [WORD_W-1:0] TC_FIELD_MASK = 32'hF800_18FF;

  typedef struct packed {
    logic statusWe;
    logic tcWe;
    logic tcToActive;
  } wrStrobes_t;

  function automatic logic [WORD_W-1:0] tcMerge(input logic [WORD_W-1:0] oldTc,
                                                input logic [WORD_W-1:0] st,
                                                input logic [ASID_W-1:0] asid);
    logic [WORD_W-1:0] ins;
    ins = '0;
    ins[TC_TCU_HI:TC_TCU_LO] = st[ST_CU_HI:ST_CU_LO];
    ins[TC_TMX] = st[ST_MX];
    ins[TC_TKSU_HI:TC_TKSU_LO] = st[ST_KSU_HI:ST_KSU_LO];
    ins[TC_ASID_HI:0] = asid;
    return (oldTc & ~TC_FIELD_MASK) | ins;
  endfunction
endpackage

// File: rtl/status_wr_ctrl.sv
module status_wr_ctrl
  import stat_wr_pkg::*;
#(
  parameter int TC_IDX_W = 2
) (
  input  logic                wrEn,
  input  logic                userMode,
  input  logic                r6Mode,
  input  logic                mtEnable,
  input  logic [WORD_W-1:0]   wrData,
  input  logic [WORD_W-1:0]   rwMask,
  input  logic [TC_IDX_W-1:0] targetTc,
  input  logic [TC_IDX_W-1:0] currentTc,
  output wrStrobes_t          strb,
  output logic [WORD_W-1:0]   effMask
);
  logic hasSupervisor;
  logic ksuReserved;
  logic [WORD_W-1:0] setOnlyBits;

  always_comb begin
    hasSupervisor = (rwMask[ST_KSU_HI:ST_KSU_LO] == 2'b11);
    ksuReserved = (wrData[ST_KSU_HI:ST_KSU_LO] == 2'b11);
    setOnlyBits = '0;
    setOnlyBits[ST_SR] = 1'b1;
    setOnlyBits[ST_NMI] = 1'b1;
    effMask = rwMask;
    if (r6Mode) begin
      if (hasSupervisor && ksuReserved) effMask[ST_KSU_HI:ST_KSU_LO] = 2'b00;
      effMask = effMask & ~(setOnlyBits & wrData);
    end
  end

  always_comb begin
    strb.statusWe = wrEn && !userMode;
    strb.tcWe = wrEn && !userMode && mtEnable;
    strb.tcToActive = (targetTc == currentTc);
  end
endmodule

// File: rtl/status_wr_dpath.sv
module status_wr_dpath
  import stat_wr_pkg::*;
#(
  parameter int NUM_TC = 4,
  parameter int TC_IDX_W = 2,
  parameter logic [31:0] RESET_STATUS = 32'h0040_0004
) (
  input  logic                     clk,
  input  logic                     rst,
  input  wrStrobes_t               strb,
  input  logic [WORD_W-1:0]        effMask,
  input  logic [WORD_W-1:0]        wrData,
  input  logic [ASID_W-1:0]        asidIn,
  input  logic [TC_IDX_W-1:0]      targetTc,
  output logic [WORD_W-1:0]        statusQ,
  output logic [WORD_W-1:0]        activeQ,
  output logic [NUM_TC*WORD_W-1:0] entriesQ
);
  logic [WORD_W-1:0] nextStatus;

  assign nextStatus = (statusQ & ~effMask) | (wrData & effMask);

  always_ff @(posedge clk) begin
    if (rst) statusQ <= RESET_STATUS;
    else if (strb.statusWe) statusQ <= nextStatus;
  end

  always_ff @(posedge clk) begin
    if (rst) activeQ <= '0;
    else if (strb.tcWe && strb.tcToActive) activeQ <= tcMerge(activeQ, nextStatus, asidIn);
  end

  for (genvar i = 0; i < NUM_TC; i++) begin : g_entry
    logic [WORD_W-1:0] entryQ;
    always_ff @(posedge clk) begin
      if (rst) entryQ <= '0;
      else if (strb.tcWe && !strb.tcToActive && (targetTc == TC_IDX_W'(i)))
        entryQ <= tcMerge(entryQ, nextStatus, asidIn);
    end
    assign entriesQ[i*WORD_W +: WORD_W] = entryQ;
  end

  assert_reset_state_R2: assert property (@(posedge clk)
    rst |=> (statusQ == RESET_STATUS && activeQ == '0 && entriesQ == '0));
  assert_indexed_leaves_active_R8: assert property (@(posedge clk) disable iff (rst)
    (strb.tcWe && !strb.tcToActive) |=> $stable(activeQ));
  assert_active_leaves_entries_R8: assert property (@(posedge clk) disable iff (rst)
    (strb.tcWe && strb.tcToActive) |=> $stable(entriesQ));
  assert_tc_needs_status_R9: assert property (@(posedge clk) disable iff (rst)
    strb.tcWe |-> strb.statusWe);
endmodule

// File: rtl/status_wr_unit.sv
module status_wr_unit
  import stat_wr_pkg::*;
#(
  parameter int NUM_TC = 4,
  parameter int TC_IDX_W = (NUM_TC > 1) ? $clog2(NUM_TC) : 1,
  parameter logic [31:0] RESET_STATUS = 32'h0040_0004
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wrEn,
  input  logic [31:0]              wrData,
  input  logic [31:0]              rwMask,
  input  logic                     r6Mode,
  input  logic                     mtEnable,
  input  logic                     userMode,
  input  logic [7:0]               asidIn,
  input  logic [TC_IDX_W-1:0]      targetTc,
  input  logic [TC_IDX_W-1:0]      currentTc,
  output logic [31:0]              statusOut,
  output logic [31:0]              activeTcStatus,
  output logic [NUM_TC*32-1:0]     tcStatusFlat
);
  wrStrobes_t strb;
  logic [WORD_W-1:0] effMask;

  status_wr_ctrl #(.TC_IDX_W(TC_IDX_W)) u_ctrl (
    .wrEn(wrEn), .userMode(userMode), .r6Mode(r6Mode), .mtEnable(mtEnable),
    .wrData(wrData), .rwMask(rwMask), .targetTc(targetTc), .currentTc(currentTc),
    .strb(strb), .effMask(effMask)
  );

  status_wr_dpath #(.NUM_TC(NUM_TC), .TC_IDX_W(TC_IDX_W), .RESET_STATUS(RESET_STATUS)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .effMask(effMask), .wrData(wrData),
    .asidIn(asidIn), .targetTc(targetTc), .statusQ(statusOut),
    .activeQ(activeTcStatus), .entriesQ(tcStatusFlat)
  );

  assert_mask_guard_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((statusOut ^ $past(statusOut)) & ~$past(rwMask)) == '0));
  assert_user_blocked_R10: assert property (@(posedge clk) disable iff (rst)
    (userMode || !wrEn) |=> ($stable(statusOut) && $stable(activeTcStatus) && $stable(tcStatusFlat)));
  assert_sr_not_set_R4: assert property (@(posedge clk) disable iff (rst)
    (r6Mode && wrData[ST_SR]) |=> $stable(statusOut[ST_SR]));
  assert_nmi_not_set_R4: assert property (@(posedge clk) disable iff (rst)
    (r6Mode && wrData[ST_NMI]) |=> $stable(statusOut[ST_NMI]));
  assert_mt_off_R9: assert property (@(posedge clk) disable iff (rst)
    !mtEnable |=> ($stable(activeTcStatus) && $stable(tcStatusFlat)));
  assert_active_copy_R6: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !userMode && mtEnable && targetTc == currentTc) |=>
      (activeTcStatus[TC_TCU_HI:TC_TCU_LO] == statusOut[ST_CU_HI:ST_CU_LO] &&
       activeTcStatus[TC_TMX] == statusOut[ST_MX] &&
       activeTcStatus[TC_TKSU_HI:TC_TKSU_LO] == statusOut[ST_KSU_HI:ST_KSU_LO]));
endmodule

// File: tb/status_wr_unit_bench.sv
module status_wr_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_TC = 4;
  localparam int TC_IDX_W = 2;
  localparam logic [31:0] RST_VAL = 32'h0040_0004;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rwMask = '0;
  logic r6Mode = 1'b0;
  logic mtEnable = 1'b0;
  logic userMode = 1'b0;
  logic [7:0] asidIn = '0;
  logic [TC_IDX_W-1:0] targetTc = '0;
  logic [TC_IDX_W-1:0] currentTc = '0;
  logic [31:0] statusOut;
  logic [31:0] activeTcStatus;
  logic [NUM_TC*32-1:0] tcStatusFlat;

  int testsRun = 0;
  int testsFailed = 0;
  int cycleCount = 0;
  logic [31:0] mStatus;
  logic [31:0] mActive;
  logic [NUM_TC*32-1:0] mEntries;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_wr_unit #(.NUM_TC(NUM_TC), .RESET_STATUS(RST_VAL)) u_status_wr_unit (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rwMask(rwMask),
    .r6Mode(r6Mode), .mtEnable(mtEnable), .userMode(userMode), .asidIn(asidIn),
    .targetTc(targetTc), .currentTc(currentTc), .statusOut(statusOut),
    .activeTcStatus(activeTcStatus), .tcStatusFlat(tcStatusFlat)
  );

  function automatic logic [31:0] refMask(input logic [31:0] d, input logic [31:0] m, input logic r6);
    logic [31:0] e;
    e = m;
    if (r6) begin
      if (m[4:3] == 2'b11 && d[4:3] == 2'b11) e[4:3] = 2'b00;
      if (d[20]) e[20] = 1'b0;
      if (d[19]) e[19] = 1'b0;
    end
    return e;
  endfunction

  function automatic logic [31:0] refTc(input logic [31:0] old, input logic [31:0] st, input logic [7:0] a);
    logic [31:0] r;
    r = old;
    r[31:28] = st[31:28];
    r[27] = st[24];
    r[12:11] = st[4:3];
    r[7:0] = a;
    return r;
  endfunction

  task automatic checkAll(input string tag);
    testsRun++;
    if (statusOut !== mStatus) begin
      testsFailed++;
      $display("FAIL %s status actual=%h expected=%h", tag, statusOut, mStatus);
    end
    testsRun++;
    if (activeTcStatus !== mActive || tcStatusFlat !== mEntries) begin
      testsFailed++;
      $display("FAIL %s tcstatus actual=%h/%h expected=%h/%h", tag,
               activeTcStatus, tcStatusFlat, mActive, mEntries);
    end
  endtask

  task automatic step(input logic we, input logic [31:0] d, input logic [31:0] m,
                      input logic r6, input logic mt, input logic um, input logic [7:0] a,
                      input logic [1:0] tgt, input logic [1:0] cur, input string tag);
    logic [31:0] e;
    wrEn = we; wrData = d; rwMask = m; r6Mode = r6; mtEnable = mt;
    userMode = um; asidIn = a; targetTc = tgt; currentTc = cur;
    if (we && !um) begin
      e = refMask(d, m, r6);
      mStatus = (mStatus & ~e) | (d & e);
      if (mt) begin
        if (tgt == cur) mActive = refTc(mActive, mStatus, a);
        else mEntries[tgt*32 +: 32] = refTc(mEntries[tgt*32 +: 32], mStatus, a);
      end
    end
    @(negedge clk);
    checkAll(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycleCount++;
      if (cycleCount > 100000) begin
        testsFailed++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
        $finish;
      end
    end
  end

  initial begin
    mStatus = RST_VAL; mActive = '0; mEntries = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    checkAll("R2");
    // R1: only masked bits move
    step(1, 32'hFFFF_FFFF, 32'h0000_FF00, 0, 0, 0, 8'h00, 0, 0, "R1");
    step(1, 32'h0000_0000, 32'h0000_0F00, 0, 0, 0, 8'h00, 0, 0, "R1");
    // R5: no filtering outside release-6
    step(1, 32'h0018_0018, 32'hFFFF_FFFF, 0, 0, 0, 8'h00, 0, 0, "R5");
    step(1, 32'h0000_0000, 32'h0018_0018, 0, 0, 0, 8'h00, 0, 0, "R5");
    // R3: reserved privilege value dropped in release-6 with supervisor
    step(1, 32'h0000_0010, 32'h0000_0018, 1, 0, 0, 8'h00, 0, 0, "R3");
    step(1, 32'h0000_0018, 32'h0000_0018, 1, 0, 0, 8'h00, 0, 0, "R3");
    step(1, 32'h0000_0018, 32'h0000_0008, 1, 0, 0, 8'h00, 0, 0, "R3");
    // R4: SR/NMI cannot be set, can be cleared
    step(1, 32'h0018_0000, 32'h0018_0000, 1, 0, 0, 8'h00, 0, 0, "R4");
    step(1, 32'h0018_0000, 32'h0018_0000, 0, 0, 0, 8'h00, 0, 0, "R4");
    step(1, 32'h0000_0000, 32'h0018_0000, 1, 0, 0, 8'h00, 0, 0, "R4");
    // R10: user mode blocks writes
    step(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1, 1, 8'hAA, 1, 1, "R10");
    // R6 / R7 / R11: active context mirror visible after one edge
    step(1, 32'hA100_0008, 32'hFFFF_FFFF, 0, 1, 0, 8'h5C, 2, 2, "R6");
    step(1, 32'h5000_0010, 32'hFFFF_FFFF, 0, 1, 0, 8'h3E, 1, 1, "R7");
    step(1, 32'h3100_0018, 32'hF100_0018, 0, 1, 0, 8'h77, 3, 3, "R11");
    // R8: indexed entries
    step(1, 32'h9000_0008, 32'hFFFF_FFFF, 0, 1, 0, 8'h11, 1, 0, "R8");
    step(1, 32'h6100_0010, 32'hFFFF_FFFF, 0, 1, 0, 8'h22, 3, 2, "R8");
    step(1, 32'h1000_0000, 32'hFFFF_FFFF, 0, 1, 0, 8'h33, 0, 1, "R8");
    // R9: MT disabled leaves TCStatus alone
    step(1, 32'hF100_0018, 32'hFFFF_FFFF, 0, 0, 0, 8'hEE, 2, 1, "R9");
    step(0, 32'h0, 32'h0, 0, 1, 0, 8'h00, 0, 0, "R10");
    // Random mix
    begin
      int seedDummy;
      seedDummy = $urandom(32'd12345);
    end
    for (int i = 0; i < 600; i++) begin
      logic [31:0] d;
      logic [31:0] m;
      d = $urandom;
      m = $urandom;
      if ($urandom_range(3) == 0) m = 32'hFFFF_FFFF;
      if ($urandom_range(3) == 0) d[4:3] = 2'b11;
      step($urandom_range(4) != 0, d, m, 1'($urandom_range(1)), 1'($urandom_range(1)),
           $urandom_range(7) == 0, 8'($urandom), 2'($urandom_range(3)),
           2'($urandom_range(3)), "R1/R3/R4/R6/R8");
    end
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule